// File: doc/BRIEF.md
# Rotate and Mirror Frame Read Address Generator

This block produces the sequence of frame-buffer read addresses that turns a stored image into a rotated output image. The output can be turned by 0°, 90°, 180° or 270°, and the image can also be flipped left to right. The flip is applied to the source image before it is rotated. No pixel passes through the block. The whole transform comes from the order in which the output stage fetches the stored frame, so no processing engine is needed.

Software sets the source width and height, the buffer base address, the line stride, the rotation code and the mirror flag, and then pulses `start`. The block checks the geometry against the output width limits. If the geometry is legal, it streams one byte address per output pixel in output raster order over a valid/ready handshake. Each address carries end-of-line and end-of-frame markers. The address walk is incremental: one multiply finds the first pixel when the frame is loaded, and after that each pixel is reached by adding a fixed step.

Top module: `rm_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `cfg_err` is 0.
- R2: The rotation codes are 0=0°, 1=90°, 2=180° and 3=270°. With code 0 and no mirror, the output is Win×Hin. Output pixel (u,v) reads source (x=u, y=v) at address base + y·stride + x·BPP, where BPP is the bytes-per-pixel parameter.
- R3: With code 1, the output is Hin wide and Win tall. Output (u,v) reads source (x=v, y=Hin-1-u).
- R4: With code 2, the output is Win×Hin. Output (u,v) reads source (x=Win-1-u, y=Hin-1-v).
- R5: With code 3, the output is Hin wide and Win tall. Output (u,v) reads source (x=Win-1-v, y=u).
- R6: When the mirror flag is 1, the x given by the rotation mapping is replaced by Win-1-x, for every rotation code.
- R7: `out_eol` is 1 on the last pixel of each output row. `out_eof` is 1 only on the final pixel of the frame, together with `out_eol`. After that pixel is accepted, `out_valid` falls.
- R8: While `out_valid` is 1 and `out_ready` is 0, the address and both markers hold their values.
- R9: A start with code 0 or 2 and Win greater than MAX_OUT_W (default 2048), or with any zero dimension, sets `cfg_err` and produces no output. Win equal to MAX_OUT_W is accepted. A later legal start clears `cfg_err`.
- R10: A start with code 1 or 3 and Hin greater than MAX_ROT_H (default 1088) sets `cfg_err` and produces no output. Hin equal to MAX_ROT_H is accepted. Win above MAX_OUT_W is allowed with these codes. Code 2 places no limit on Hin.
- R11: Configuration is captured at an accepted start. A `start` or a change to any configuration input while a frame is streaming has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | DIM_W | Source image width in pixels |
| cfg_height | input | DIM_W | Source image height in lines |
| cfg_base | input | ADDR_W | Byte address of source pixel (0,0) |
| cfg_stride | input | STRIDE_W | Bytes between source lines |
| cfg_rot | input | 2 | Rotation code |
| cfg_mirror | input | 1 | Flip source left to right before rotation |
| start | input | 1 | Frame start request, honoured only when idle |
| out_valid | output | 1 | Address beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | ADDR_W | Byte address of the next output pixel |
| out_eol | output | 1 | Beat is the last pixel of an output row |
| out_eof | output | 1 | Beat is the last pixel of the frame |
| cfg_err | output | 1 | Last start request had illegal geometry |

## Verification
The hardest cases to reach are the limit boundaries, because each legal boundary frame is long: a full 2048-pixel row for code 0, or a 1088-row column for code 1. The stimulus shrinks the other dimension to one, so that every boundary frame runs to completion and every address in it can be checked. A second hard case is a `start` pulse and scrambled configuration inputs arriving in the middle of a frame. The stimulus drives this while `out_ready` toggles in a stall pattern, and then checks that the frame that was already running is unchanged.

// File: rtl/rm_pkg.sv
// Shared types for the rotate/mirror address generator.
// Assumes the rotation code is the plain two-bit encoding given in the brief.
package rm_pkg;
    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_e;

    // True when the rotation swaps the horizontal and vertical extents.
    function automatic logic axes_swapped(rot_e r);
        return (r == ROT_90) || (r == ROT_270);
    endfunction
endpackage

// File: rtl/rm_geom.sv
// Geometry decoder: from the source size, rotation, mirror and stride, works out
// the byte offset of output pixel (0,0), the signed address steps along an output
// row (u) and down an output column (v), the output extents minus one, and whether
// the size breaks a limit. Purely combinational; evaluated once at frame load.
// Assumes the stride and size fit the address width, and that ADDR_W arithmetic wraps.
module rm_geom
    import rm_pkg::*;
#(
    parameter int DIM_W     = 12,
    parameter int ADDR_W    = 32,
    parameter int STRIDE_W  = 16,
    parameter int BPP       = 4,
    parameter int MAX_OUT_W = 2048,
    parameter int MAX_ROT_H = 1088
) (
    input  logic [DIM_W-1:0]    width,
    input  logic [DIM_W-1:0]    height,
    input  rot_e                rot,
    input  logic                mirror,
    input  logic [STRIDE_W-1:0] stride,
    output logic [ADDR_W-1:0]   start_off,
    output logic [ADDR_W-1:0]   step_u,
    output logic [ADDR_W-1:0]   step_v,
    output logic [DIM_W-1:0]    wout_m1,
    output logic [DIM_W-1:0]    hout_m1,
    output logic                bad
);
    localparam logic [DIM_W-1:0] LIM_W = DIM_W'(MAX_OUT_W);
    localparam logic [DIM_W-1:0] LIM_H = DIM_W'(MAX_ROT_H);
    localparam logic [DIM_W-1:0] ONE   = DIM_W'(1);

    logic [ADDR_W-1:0] px, ln, x_fwd, x_rev, y_fwd, y_rev;
    logic [DIM_W-1:0]  w_m1, h_m1, x0p, x0, y0;
    logic              swap;

    // Pick the corner and unit steps for the requested orientation.
    always_comb begin
        px    = ADDR_W'(BPP);
        ln    = ADDR_W'(stride);
        x_fwd = mirror ? -px : px;
        x_rev = -x_fwd;
        y_fwd = ln;
        y_rev = -ln;
        w_m1  = width - ONE;
        h_m1  = height - ONE;
        swap  = axes_swapped(rot);
        unique case (rot)
            ROT_0:   begin x0p = '0;   y0 = '0;   step_u = x_fwd; step_v = y_fwd; end
            ROT_90:  begin x0p = '0;   y0 = h_m1; step_u = y_rev; step_v = x_fwd; end
            ROT_180: begin x0p = w_m1; y0 = h_m1; step_u = x_rev; step_v = y_rev; end
            default: begin x0p = w_m1; y0 = '0;   step_u = y_fwd; step_v = x_rev; end
        endcase
        x0        = mirror ? (w_m1 - x0p) : x0p;
        start_off = ADDR_W'(y0) * ln + ADDR_W'(x0) * px;
        wout_m1   = swap ? h_m1 : w_m1;
        hout_m1   = swap ? w_m1 : h_m1;
        bad       = (width == '0) || (height == '0) ||
                    (swap ? (height > LIM_H) : (width > LIM_W));
    end
endmodule

// File: rtl/rm_walker.sv
// Address walker: on load, captures the first address, the steps and the extents,
// then emits one address per accepted beat in output raster order. It adds the row
// step to a row-start register at each line end and the pixel step inside a line,
// so the loop has adders only. Assumes load is raised only while idle.
module rm_walker #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] step_u,
    input  logic [ADDR_W-1:0] step_v,
    input  logic [DIM_W-1:0]  wout_m1,
    input  logic [DIM_W-1:0]  hout_m1,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_eol,
    output logic              out_eof
);
    logic              active;
    logic [DIM_W-1:0]  u, v, wl, hl;
    logic [ADDR_W-1:0] cur, row, su, sv;
    logic              fire;

    assign fire      = active && out_ready;
    assign out_valid = active;
    assign out_addr  = cur;
    assign out_eol   = active && (u == wl);
    assign out_eof   = out_eol && (v == hl);

    // Advance the output position and the running address on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            u <= '0; v <= '0; wl <= '0; hl <= '0;
            cur <= '0; row <= '0; su <= '0; sv <= '0;
        end else if (load) begin
            active <= 1'b1;
            u <= '0; v <= '0;
            wl <= wout_m1; hl <= hout_m1;
            cur <= first_addr; row <= first_addr;
            su <= step_u; sv <= step_v;
        end else if (fire) begin
            if (out_eof) begin
                active <= 1'b0;
            end else if (out_eol) begin
                u   <= '0;
                v   <= v + DIM_W'(1);
                row <= row + sv;
                cur <= row + sv;
            end else begin
                u   <= u + DIM_W'(1);
                cur <= cur + su;
            end
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_eol) && $stable(out_eof)));
    assert_frame_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> !out_valid);
    assert_col_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (u <= wl) && (v <= hl));
endmodule

// File: rtl/rm_addr_gen.sv
// Top of the rotate/mirror read address generator. Accepts a start only while no
// frame is streaming; checks the geometry, reports an error and stays idle for an
// illegal size, otherwise loads the walker with the decoded geometry.
// Assumes configuration inputs are stable in the cycle start is raised.
module rm_addr_gen
    import rm_pkg::*;
#(
    parameter int DIM_W     = 12,
    parameter int ADDR_W    = 32,
    parameter int STRIDE_W  = 16,
    parameter int BPP       = 4,
    parameter int MAX_OUT_W = 2048,
    parameter int MAX_ROT_H = 1088
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIM_W-1:0]    cfg_width,
    input  logic [DIM_W-1:0]    cfg_height,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [1:0]          cfg_rot,
    input  logic                cfg_mirror,
    input  logic                start,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic                out_eol,
    output logic                out_eof,
    output logic                cfg_err
);
    logic [ADDR_W-1:0] start_off, step_u, step_v;
    logic [DIM_W-1:0]  wout_m1, hout_m1;
    logic              geom_bad, take, load;

    assign take = start && !out_valid;
    assign load = take && !geom_bad;

    rm_geom #(
        .DIM_W(DIM_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .BPP(BPP),
        .MAX_OUT_W(MAX_OUT_W), .MAX_ROT_H(MAX_ROT_H)
    ) u_geom (
        .width(cfg_width), .height(cfg_height), .rot(rot_e'(cfg_rot)),
        .mirror(cfg_mirror), .stride(cfg_stride),
        .start_off(start_off), .step_u(step_u), .step_v(step_v),
        .wout_m1(wout_m1), .hout_m1(hout_m1), .bad(geom_bad)
    );

    rm_walker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load),
        .first_addr(cfg_base + start_off), .step_u(step_u), .step_v(step_v),
        .wout_m1(wout_m1), .hout_m1(hout_m1), .out_ready(out_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_eol(out_eol), .out_eof(out_eof)
    );

    // Record the verdict of each start request honoured while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_err <= 1'b0;
        else if (take) cfg_err <= geom_bad;
    end

    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && geom_bad) |=> (!out_valid && cfg_err));
    assert_clean_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !cfg_err);
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && start) |=> $stable(cfg_err));
endmodule

// File: tb/sim_rm_addr_gen.sv
module sim_rm_addr_gen;
    localparam int DIM_W = 12, ADDR_W = 32, STRIDE_W = 16, BPP = 4;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int STRIDE = 16'h2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [DIM_W-1:0] cfg_width = '0, cfg_height = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [STRIDE_W-1:0] cfg_stride = '0;
    logic [1:0] cfg_rot = '0;
    logic cfg_mirror = 1'b0, start = 1'b0, out_ready = 1'b0;
    logic out_valid, out_eol, out_eof, cfg_err;
    logic [ADDR_W-1:0] out_addr;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    rm_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_rot(cfg_rot),
        .cfg_mirror(cfg_mirror), .start(start), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_eol(out_eol),
        .out_eof(out_eof), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_addr(int u, int v, int w, int h, int rot, bit mir);
        int x, y;
        case (rot)
            0: begin x = u;         y = v;         end
            1: begin x = v;         y = h - 1 - u; end
            2: begin x = w - 1 - u; y = h - 1 - v; end
            default: begin x = w - 1 - v; y = u;   end
        endcase
        if (mir) x = w - 1 - x;
        return BASE + 32'(y) * 32'(STRIDE) + 32'(x) * 32'(BPP);
    endfunction

    task automatic drive_cfg(input int w, input int h, input int rot, input bit mir);
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        cfg_base = BASE; cfg_stride = STRIDE_W'(STRIDE);
        cfg_rot = 2'(rot); cfg_mirror = mir;
    endtask

    // One legal frame: checks every address and marker, stall holding, and the frame end.
    task automatic run_frame(input int w, input int h, input int rot, input bit mir,
                             input bit stall, input bit poke, input string req);
        int ow, oh, n, u, v, guard, bad_a, bad_m, bad_s;
        logic [31:0] held, fa, fe;
        bit waited;
        ow = (rot % 2 == 1) ? h : w;
        oh = (rot % 2 == 1) ? w : h;
        n = 0; u = 0; v = 0; guard = 0; bad_a = 0; bad_m = 0; bad_s = 0;
        waited = 0; held = '0; fa = '0; fe = '0;
        @(negedge clk);
        drive_cfg(w, h, rot, mir);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < ow * oh && guard < 20000) begin
            if (poke && n == 3) begin
                drive_cfg(w + 1, h + 2, (rot + 1) % 4, !mir);
                cfg_base = 32'h0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (waited && (!out_valid || out_addr !== held)) bad_s++;
            out_ready = stall ? (guard % 3 != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (out_addr !== ref_addr(u, v, w, h, rot, mir)) begin
                    if (bad_a == 0) begin fa = out_addr; fe = ref_addr(u, v, w, h, rot, mir); end
                    bad_a++;
                end
                if (out_eol !== (u == ow - 1) || out_eof !== (u == ow - 1 && v == oh - 1)) bad_m++;
                if (u == ow - 1) begin u = 0; v++; end else u++;
                n++;
                waited = 0;
            end else if (out_valid) begin
                waited = 1;
                held = out_addr;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check(bad_a == 0 && n == ow * oh, req, "address sequence", longint'(fa), longint'(fe));
        check(bad_m == 0, "R7", "eol/eof markers mismatches", bad_m, 0);
        check(out_valid == 1'b0, "R7", "valid after last beat", out_valid, 0);
        check(cfg_err == 1'b0, req, "cfg_err after legal start", cfg_err, 0);
        if (stall) check(bad_s == 0, "R8", "hold under backpressure mismatches", bad_s, 0);
        if (poke) check(bad_a == 0, "R11", "frame unchanged by mid-frame start/config", longint'(fa), longint'(fe));
    endtask

    // One illegal start: error flag set, nothing streamed.
    task automatic run_bad(input int w, input int h, input int rot, input string req);
        int seen;
        seen = 0;
        @(negedge clk);
        drive_cfg(w, h, rot, 1'b0);
        out_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        check(cfg_err == 1'b1, req, "cfg_err after illegal start", cfg_err, 1);
        check(seen == 0, req, "beats after illegal start", seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(cfg_err == 1'b0, "R1", "cfg_err after reset", cfg_err, 0);

        run_frame(5, 3, 0, 1'b0, 1'b0, 1'b0, "R2");
        run_frame(5, 3, 1, 1'b0, 1'b0, 1'b0, "R3");
        run_frame(5, 3, 2, 1'b0, 1'b0, 1'b0, "R4");
        run_frame(5, 3, 3, 1'b0, 1'b0, 1'b0, "R5");
        for (int r = 0; r < 4; r++) run_frame(4, 3, r, 1'b1, 1'b1, 1'b0, "R6");
        run_frame(7, 2, 1, 1'b0, 1'b1, 1'b0, "R8");
        run_frame(6, 4, 3, 1'b1, 1'b1, 1'b1, "R11");

        run_bad(2049, 4, 0, "R9");
        run_bad(2049, 4, 2, "R9");
        run_bad(5, 0, 0, "R9");
        run_frame(2048, 1, 0, 1'b0, 1'b0, 1'b0, "R9");
        run_bad(4, 1089, 1, "R10");
        run_bad(4, 1089, 3, "R10");
        run_frame(1, 1088, 1, 1'b0, 1'b0, 1'b0, "R10");
        run_frame(2049, 1, 3, 1'b1, 1'b0, 1'b0, "R10");
        run_frame(1, 1089, 2, 1'b0, 1'b0, 1'b0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule